// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit works out the word address that a load, store or address-load instruction refers to, in a processor with a 16-bit, word-addressed memory space. It decodes the opcode in the instruction word. It adds a sign-extended offset to either the incremented program counter or a base register value, and it reports one result per accepted request. The register file reads the base register beforehand, using instruction bits 8:6. The result is the address, a flag saying that memory must be accessed, and a flag saying that the address lies outside the user window 0x3000 to 0xFDFF.

For the indirect forms the unit first issues its own read of the pointer word at the PC-relative address, waits for the reply, and then reports that word as the final address. All additions wrap modulo 2^16. The memory, the register file and the writeback of data are outside this unit.

Top module: `lsea_unit`

## Requirements
- R1: After reset, done, rd_req, mem_access and violation are 0 and ea is 0x0000.
- R2: For opcodes 0010 and 0011 (PC-relative), done pulses for one cycle one clock after start is sampled, and ea = pc_next + sign-extended instr[8:0], wrapping modulo 2^16.
- R3: For opcodes 0110 and 0111 (base plus offset), done pulses one clock after start, and ea = base_val + sign-extended instr[5:0].
- R4: For opcode 1110 (address load), done pulses one clock after start, ea = pc_next + sign-extended instr[8:0], and mem_access and violation are both 0, even for an address outside the user window.
- R5: For every access opcode, violation is 1 exactly when the reported address lies outside 0x3000..0xFDFF inclusive, and mem_access is the inverse of violation.
- R6: For opcodes 1010 and 1011 (indirect), rd_req is high for exactly the one cycle after start, with rd_addr = pc_next + sign-extended instr[8:0]. The word on rd_data in the cycle after rd_req is sampled, and done follows one cycle later (three clocks after start) with ea equal to that word.
- R7: For an indirect opcode whose pointer address lies outside the user window, no read is issued. done pulses one clock after start with ea set to the pointer address, violation 1 and mem_access 0.
- R8: Any other opcode gives done one clock after start, with ea 0x0000 and mem_access and violation both 0.
- R9: start is ignored while an indirect request is in progress, so that request yields exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled with the operand inputs |
| instr | input | 16 | Instruction word; opcode in bits 15:12 |
| pc_next | input | 16 | Already-incremented program counter |
| base_val | input | 16 | Base register value from the register file |
| rd_data | input | 16 | Pointer word returned the cycle after rd_req |
| rd_req | output | 1 | Pointer read request for the indirect forms |
| rd_addr | output | 16 | Address of the pointer read |
| done | output | 1 | One-cycle pulse: result is valid |
| ea | output | 16 | Effective address, held until the next result |
| mem_access | output | 1 | Memory must be accessed at ea |
| violation | output | 1 | Address outside the user window |

## Verification
The hardest case to reach is a start that arrives while an indirect request is still waiting for its pointer word, because the port sequence must overlap two requests. The stimulus holds start high for three cycles across the read and wait steps of a store-indirect, and it changes the opcode to a direct load while it does so. A second awkward case is an indirect request whose pointer location is itself outside the window. For that case the bench places the PC below 0x3000 and confirms that no read request ever appears and that the result comes early.

// File: rtl/lsea_unit.sv
module lsea_unit #(
  parameter logic [15:0] WIN_LO = 16'h3000,
  parameter logic [15:0] WIN_HI = 16'hFDFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [15:0] pc_next,
  input  logic [15:0] base_val,
  input  logic [15:0] rd_data,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  output logic        done,
  output logic [15:0] ea,
  output logic        mem_access,
  output logic        violation
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t         st;
  logic [15:0] ptr_q;
  logic [3:0]  op;
  logic [15:0] pcrel, based, sel_addr;
  logic        is_acc, is_ind, is_lea, is_base;
  logic        unused_bits;

  function automatic logic in_win(input logic [15:0] a);
    return (a >= WIN_LO) && (a <= WIN_HI);
  endfunction

  assign op          = instr[15:12];
  assign unused_bits = ^instr[11:9];
  assign pcrel       = pc_next + {{7{instr[8]}}, instr[8:0]};
  assign based       = base_val + {{10{instr[5]}}, instr[5:0]};
  assign is_base     = (op == 4'b0110) || (op == 4'b0111);
  assign is_acc      = (op == 4'b0010) || (op == 4'b0011) || is_base;
  assign is_ind      = (op == 4'b1010) || (op == 4'b1011);
  assign is_lea      = (op == 4'b1110);
  assign sel_addr    = is_base ? based : pcrel;

  assign rd_req  = (st == S_REQ);
  assign rd_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr_q      <= '0;
      done       <= 1'b0;
      ea         <= '0;
      mem_access <= 1'b0;
      violation  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (is_ind && in_win(pcrel)) begin
            ptr_q <= pcrel;
            st    <= S_REQ;
          end else begin
            done       <= 1'b1;
            ea         <= (is_acc || is_ind || is_lea) ? sel_addr : 16'h0000;
            violation  <= (is_acc || is_ind) && !in_win(sel_addr);
            mem_access <= is_acc && in_win(sel_addr);
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          done       <= 1'b1;
          ea         <= rd_data;
          violation  <= !in_win(rd_data);
          mem_access <= in_win(rd_data);
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  rd_req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R6
  rd_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !done ##2 done);

  // R4
  lea_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && op == 4'b1110) |=> done && !mem_access && !violation);

  // R5
  access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_access && violation));

  // R5
  window_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_access) |-> (ea >= WIN_LO && ea <= WIN_HI));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> !rd_req || $past(st == S_IDLE));

endmodule

// File: tb/sim_lsea_unit.sv
module sim_lsea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_next = '0, base_val = '0, rd_data = '0;
  logic        rd_req, done, mem_access, violation;
  logic [15:0] rd_addr, ea;

  lsea_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .pc_next(pc_next), .base_val(base_val), .rd_data(rd_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .done(done), .ea(ea), .mem_access(mem_access),
    .violation(violation));

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] ea;
    logic        acc;
    logic        viol;
    int          lat;
    string       rq;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] addrq[$];
  int          checks = 0, fails = 0, cyc = 0, t0 = 0;
  logic [15:0] ptr_val = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rd_req) rd_data <= ptr_val;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction
  function automatic logic [15:0] sx6(input logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction
  function automatic logic inw(input logic [15:0] a);
    return a >= 16'h3000 && a <= 16'hFDFF;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) chk("R9", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(e.rq, "ea", ea, e.ea);
        chk(e.rq, "mem_access", mem_access, e.acc);
        chk(e.rq, "violation", violation, e.viol);
        chk(e.rq, "latency", cyc - t0, e.lat);
      end
    end
    if (rst_n && rd_req) begin
      if (addrq.size() == 0) chk("R7", "unexpected rd_req", 1, 0);
      else chk("R6", "rd_addr", rd_addr, addrq.pop_front());
    end
  end

  task automatic issue(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] base,
                       input logic [15:0] e_ea, input logic e_acc, input logic e_viol,
                       input int lat, input string rq, input int hold);
    exp_t e;
    e.ea = e_ea; e.acc = e_acc; e.viol = e_viol; e.lat = lat; e.rq = rq;
    expq.push_back(e);
    if (lat == 3) addrq.push_back(pc + sx9(ins[8:0]));
    @(negedge clk);
    instr = ins; pc_next = pc; base_val = base; start = 1'b1; t0 = cyc;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == 0) instr = {4'b0010, 12'h005};
    end
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pcrel(input logic [3:0] op, input logic [15:0] pc, input logic [8:0] off, input string rq);
    logic [15:0] a;
    a = pc + sx9(off);
    issue({op, 3'b001, off}, pc, 16'h0, a, inw(a), !inw(a), 1, rq, 1);
  endtask

  task automatic baseoff(input logic [3:0] op, input logic [15:0] b, input logic [5:0] off, input string rq);
    logic [15:0] a;
    a = b + sx6(off);
    issue({op, 3'b011, 3'b010, off}, 16'h1234, b, a, inw(a), !inw(a), 1, rq, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", done, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "ea", ea, 0);
        chk("R1", "mem_access", mem_access, 0);
        chk("R1", "violation", violation, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pcrel(4'b0010, 16'h3000, 9'h005, "R2");
        pcrel(4'b0011, 16'h4000, 9'h1FF, "R2");
        pcrel(4'b0010, 16'h3002, 9'h1FC, "R5");
        pcrel(4'b0010, 16'hFFF0, 9'h020, "R2");
        baseoff(4'b0110, 16'h5000, 6'h20, "R3");
        baseoff(4'b0111, 16'hFDF0, 6'h0F, "R5");
        baseoff(4'b0111, 16'hFDF0, 6'h10, "R5");
        baseoff(4'b0110, 16'h2FF0, 6'h10, "R5");
        // R4 address load outside window: no access, no violation
        issue({4'b1110, 3'b001, 9'h005}, 16'h0100, 16'h0, 16'h0105, 0, 0, 1, "R4", 1);
        // R6 indirect with valid pointer
        ptr_val = 16'h8000;
        issue({4'b1010, 3'b001, 9'h010}, 16'h3000, 16'h0, 16'h8000, 1, 0, 3, "R6", 1);
        ptr_val = 16'h1000;
        issue({4'b1011, 3'b001, 9'h1F0}, 16'h4000, 16'h0, 16'h1000, 0, 1, 3, "R6", 1);
        // R7 pointer location outside window
        issue({4'b1010, 3'b001, 9'h010}, 16'h2000, 16'h0, 16'h2010, 0, 1, 1, "R7", 1);
        // R8 non-memory opcode
        issue({4'b0001, 12'h0FF}, 16'h3000, 16'h3000, 16'h0000, 0, 0, 1, "R8", 1);
        // R9 start held during indirect, opcode changed to a direct load
        ptr_val = 16'hFDFF;
        issue({4'b1011, 3'b001, 9'h000}, 16'h5000, 16'h0, 16'hFDFF, 1, 0, 3, "R9", 3);
        chk("R9", "pending results", expq.size(), 0);
        chk("R7", "pending reads", addrq.size(), 0);
      end
      begin
        repeat (5000) @(posedge clk);
        chk("R1", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule